// File: doc/BRIEF.md
# Two-Stage Breaker Failure Detector

This block watches the trip commands sent to a three-pole circuit breaker and decides whether the breaker has failed to clear the fault. Several initiation latches record that a trip was issued: one for each of the three phases, one for three-phase trips, one for voltage-protection trips and one for sensitive earth-fault trips. Each latch holds until its reset condition shows that the fault current has gone.

While any latch is held, a first-stage timer counts pulses on a single-cycle tick input. When it reaches the stage-1 delay, the block raises a three-phase stage-1 breaker-fail trip and an alarm. An optional second stage then counts the remaining ticks up to the stage-2 delay and raises a stage-2 trip. The undercurrent comparators and the current measurement sit outside the block. They deliver fast undercurrent flags, one per phase plus one for earth fault.

Top module: `brkfail_stager`

## Requirements
- R1: A phase latch sets on a rising edge of the OR of that phase's external, internal and two weak-infeed trip inputs. The three-phase latch sets on a rising edge of the OR of the external and the two weak-infeed three-phase trips.
- R2: With reset code 0 (2'd0), a latch clears on its undercurrent flag alone, even while its trip input stays high.
- R3: With reset code 1 (2'd1), a latch clears only when its breaker-open input and its undercurrent are both true. A phase latch uses that phase's pole-dead input. The three-phase latch uses the all-poles-dead input and needs all three phase undercurrent flags.
- R4: With reset code 2 (2'd2), a latch clears only when its initiating trip has dropped and undercurrent is true.
- R5: The voltage-trip latch follows its own reset-code setting, separate from the code used by the phase and three-phase latches. Its undercurrent is all three phase flags, and its breaker-open input is the all-poles-dead input.
- R6: The earth-fault latch sets on a rising edge of its trip and clears on its own undercurrent flag, whatever the reset codes are.
- R7: Stage-1 trip asserts once the stage-1 delay number of tick pulses has been counted while a latch is held. A delay of zero asserts it right after the clock edge that sets the latch.
- R8: When stage 2 is enabled, the stage-2 trip asserts after a further (stage-2 delay minus stage-1 delay) ticks counted while stage 1 is asserted.
- R9: If the stage-2 delay is below the stage-1 delay, the remainder is zero, so stage 2 asserts together with stage 1.
- R10: With stage 2 disabled, the stage-2 trip never asserts.
- R11: The alarm is high whenever either stage trip is high.
- R12: When no latch is held, both stage trips are low at once, and a later initiation counts its delay from zero.
- R13: After synchronous active-low reset, all latches and counters are clear and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Single-cycle time-base pulse |
| ext_trip_ph | input | 3 | External trip per phase (bit 0 = A) |
| int_trip_ph | input | 3 | Internal protection trip per phase |
| wi1_trip_ph | input | 3 | First aided scheme weak-infeed trip per phase |
| wi2_trip_ph | input | 3 | Second aided scheme weak-infeed trip per phase |
| ext_trip_3p | input | 1 | External three-phase trip |
| wi1_trip_3p | input | 1 | First scheme weak-infeed three-phase trip |
| wi2_trip_3p | input | 1 | Second scheme weak-infeed three-phase trip |
| volt_trip | input | 1 | Any voltage-protection trip |
| sef_trip | input | 1 | Sensitive earth-fault trip |
| ucur_ph | input | 3 | Fast undercurrent flag per phase |
| sef_ucur | input | 1 | Fast undercurrent flag for earth fault |
| pole_dead | input | 3 | Pole-dead flag per phase |
| all_dead | input | 1 | All poles dead |
| trip_rst_mode | input | 2 | Reset code for phase and three-phase latches |
| volt_rst_mode | input | 2 | Reset code for the voltage latch |
| stg1_dly | input | DLY_W | Stage-1 delay in ticks |
| stg2_dly | input | DLY_W | Stage-2 total delay in ticks |
| stg2_en | input | 1 | Stage-2 enable |
| bf1_trip | output | 1 | Stage-1 breaker-fail three-phase trip |
| bf2_trip | output | 1 | Stage-2 breaker-fail three-phase trip |
| bf_alarm | output | 1 | Breaker-fail alarm |

## Verification
The timing function is driven by a vector table. Each vector starts one phase, sets a pair of delays and applies a given number of ticks. Tick counts just below and exactly at each delay separate an off-by-one error in stage 1 from one in the stage-2 remainder. Further vectors cover an inverted delay pair, a disabled stage 2 and zero delays. Directed sequences then hold each latch kind with only part of its clearing condition present and then complete it. This separates the three reset codes, the separate voltage code, the earth-fault flag and the all-poles-dead path from one another. Each trip source is also fired on its own to confirm the OR at the initiation inputs.

// File: rtl/brkfail_pkg.sv
// Shared definitions for the breaker-failure detector.
// Assumes three phases; latch index map is fixed below.
package brkfail_pkg;

    localparam int N_PH    = 3;
    localparam int L_3P    = N_PH;
    localparam int L_VOLT  = N_PH + 1;
    localparam int L_SEF   = N_PH + 2;
    localparam int N_LATCH = N_PH + 3;

    typedef enum logic [1:0] {
        CLR_UC      = 2'd0,
        CLR_OPEN_UC = 2'd1,
        CLR_PROT_UC = 2'd2,
        CLR_SPARE   = 2'd3
    } clr_mode_e;

endpackage

// File: rtl/brkfail_init_latch.sv
// One breaker-fail initiation latch.
// Sets on a rising edge of its initiation; clears by the selected
// reset condition. Set wins over clear in the same cycle.
// Assumes inputs are synchronous to clk.
module brkfail_init_latch
    import brkfail_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init,
    input  logic       ucur,
    input  logic       brk_open,
    input  logic [1:0] mode,
    output logic       held
);

    logic init_q;
    logic rise;
    logic clr;

    assign rise = init && !init_q;

    // Select the clearing condition from the reset code.
    always_comb begin
        case (clr_mode_e'(mode))
            CLR_OPEN_UC: clr = brk_open && ucur;
            CLR_PROT_UC: clr = !init && ucur;
            default:     clr = ucur;
        endcase
    end

    // Remember the initiation and update the latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= 1'b0;
            held   <= 1'b0;
        end else begin
            init_q <= init;
            if (rise)
                held <= 1'b1;
            else if (clr)
                held <= 1'b0;
        end
    end

    // R1
    latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init) |=> held);

    // R2 R3 R4: every code needs undercurrent to clear
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !ucur) |=> held);

endmodule

// File: rtl/brkfail_stage_timer.sv
// Tick counter for one breaker-fail stage.
// Counts tick pulses while run is high, saturating, and clears
// the moment run drops. done is high while run and count >= limit.
module brkfail_stage_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);

    localparam logic [W-1:0] CMAX = '1;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt;

    // Count ticks while running, restart from zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (tick && cnt != CMAX)
            cnt <= cnt + ONE;
    end

    assign done = run && (cnt >= limit);

    // R7: a stage with a fixed nonzero wait only expires after a tick
    stage_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && $past(run) && $stable(limit)) |-> $past(tick));

endmodule

// File: rtl/brkfail_stager.sv
// Two-stage breaker failure detector (top).
// Collects trip sources into six initiation latches, runs stage 1
// while any latch is held and stage 2 on the remainder after stage 1.
// Assumes undercurrent and pole-dead flags come from outside.
module brkfail_stager
    import brkfail_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [2:0]       ext_trip_ph,
    input  logic [2:0]       int_trip_ph,
    input  logic [2:0]       wi1_trip_ph,
    input  logic [2:0]       wi2_trip_ph,
    input  logic             ext_trip_3p,
    input  logic             wi1_trip_3p,
    input  logic             wi2_trip_3p,
    input  logic             volt_trip,
    input  logic             sef_trip,
    input  logic [2:0]       ucur_ph,
    input  logic             sef_ucur,
    input  logic [2:0]       pole_dead,
    input  logic             all_dead,
    input  logic [1:0]       trip_rst_mode,
    input  logic [1:0]       volt_rst_mode,
    input  logic [DLY_W-1:0] stg1_dly,
    input  logic [DLY_W-1:0] stg2_dly,
    input  logic             stg2_en,
    output logic             bf1_trip,
    output logic             bf2_trip,
    output logic             bf_alarm
);

    logic [N_LATCH-1:0] l_init;
    logic [N_LATCH-1:0] l_ucur;
    logic [N_LATCH-1:0] l_open;
    logic [1:0]         l_mode [N_LATCH];
    logic [N_LATCH-1:0] l_held;
    logic               any_held;
    logic [DLY_W-1:0]   stg2_rem;
    logic               stg2_run;
    logic               stg2_done;

    // Per-phase latch inputs.
    for (genvar p = 0; p < N_PH; p++) begin : g_phase_in
        assign l_init[p] = ext_trip_ph[p] | int_trip_ph[p]
                         | wi1_trip_ph[p] | wi2_trip_ph[p];
        assign l_ucur[p] = ucur_ph[p];
        assign l_open[p] = pole_dead[p];
        assign l_mode[p] = trip_rst_mode;
    end

    // Three-phase, voltage and earth-fault latch inputs.
    assign l_init[L_3P]   = ext_trip_3p | wi1_trip_3p | wi2_trip_3p;
    assign l_ucur[L_3P]   = &ucur_ph;
    assign l_open[L_3P]   = all_dead;
    assign l_mode[L_3P]   = trip_rst_mode;
    assign l_init[L_VOLT] = volt_trip;
    assign l_ucur[L_VOLT] = &ucur_ph;
    assign l_open[L_VOLT] = all_dead;
    assign l_mode[L_VOLT] = volt_rst_mode;
    assign l_init[L_SEF]  = sef_trip;
    assign l_ucur[L_SEF]  = sef_ucur;
    assign l_open[L_SEF]  = 1'b0;
    assign l_mode[L_SEF]  = CLR_UC;

    for (genvar i = 0; i < N_LATCH; i++) begin : g_latch
        brkfail_init_latch u_latch (
            .clk      (clk),
            .rst_n    (rst_n),
            .init     (l_init[i]),
            .ucur     (l_ucur[i]),
            .brk_open (l_open[i]),
            .mode     (l_mode[i]),
            .held     (l_held[i])
        );
    end

    assign any_held = |l_held;

    brkfail_stage_timer #(.W(DLY_W)) u_stage1 (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (any_held),
        .tick  (tick),
        .limit (stg1_dly),
        .done  (bf1_trip)
    );

    // Stage-2 remainder, floored at zero.
    always_comb begin
        if (stg2_dly > stg1_dly)
            stg2_rem = stg2_dly - stg1_dly;
        else
            stg2_rem = '0;
    end

    assign stg2_run = bf1_trip && stg2_en;

    brkfail_stage_timer #(.W(DLY_W)) u_stage2 (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (stg2_run),
        .tick  (tick),
        .limit (stg2_rem),
        .done  (stg2_done)
    );

    assign bf2_trip = stg2_done;
    assign bf_alarm = bf1_trip | bf2_trip;

    // R8
    stage_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bf2_trip |-> bf1_trip);

    // R10
    stage2_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stg2_en |-> !bf2_trip);

    // R11
    alarm_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bf1_trip || bf2_trip) |-> bf_alarm);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_held |-> (!bf1_trip && !bf2_trip));

endmodule

// File: tb/brkfail_stager_bench.sv
`timescale 1ns/1ps
module brkfail_stager_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic [2:0]  ext_trip_ph, int_trip_ph, wi1_trip_ph, wi2_trip_ph;
    logic        ext_trip_3p, wi1_trip_3p, wi2_trip_3p;
    logic        volt_trip, sef_trip;
    logic [2:0]  ucur_ph;
    logic        sef_ucur;
    logic [2:0]  pole_dead;
    logic        all_dead;
    logic [1:0]  trip_rst_mode, volt_rst_mode;
    logic [15:0] stg1_dly, stg2_dly;
    logic        stg2_en;
    logic        bf1_trip, bf2_trip, bf_alarm;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    brkfail_stager u_brkfail_stager (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .ext_trip_ph(ext_trip_ph), .int_trip_ph(int_trip_ph),
        .wi1_trip_ph(wi1_trip_ph), .wi2_trip_ph(wi2_trip_ph),
        .ext_trip_3p(ext_trip_3p), .wi1_trip_3p(wi1_trip_3p),
        .wi2_trip_3p(wi2_trip_3p), .volt_trip(volt_trip),
        .sef_trip(sef_trip), .ucur_ph(ucur_ph), .sef_ucur(sef_ucur),
        .pole_dead(pole_dead), .all_dead(all_dead),
        .trip_rst_mode(trip_rst_mode), .volt_rst_mode(volt_rst_mode),
        .stg1_dly(stg1_dly), .stg2_dly(stg2_dly), .stg2_en(stg2_en),
        .bf1_trip(bf1_trip), .bf2_trip(bf2_trip), .bf_alarm(bf_alarm)
    );

    // Vector: {phase[26:25], d1[24:17], d2[16:9], en[8], ticks[7:0]}
    localparam logic [26:0] VEC [8] = '{
        {2'd0, 8'd3, 8'd6,  1'b1, 8'd2},
        {2'd0, 8'd3, 8'd6,  1'b1, 8'd3},
        {2'd1, 8'd3, 8'd6,  1'b1, 8'd6},
        {2'd2, 8'd4, 8'd10, 1'b1, 8'd9},
        {2'd2, 8'd4, 8'd10, 1'b1, 8'd10},
        {2'd1, 8'd5, 8'd2,  1'b1, 8'd5},
        {2'd0, 8'd2, 8'd9,  1'b0, 8'd20},
        {2'd1, 8'd0, 8'd0,  1'b1, 8'd0}
    };

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic check(input logic got, input logic exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            cyc();
            tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick = 0; ext_trip_ph = 0; int_trip_ph = 0; wi1_trip_ph = 0;
        wi2_trip_ph = 0; ext_trip_3p = 0; wi1_trip_3p = 0; wi2_trip_3p = 0;
        volt_trip = 0; sef_trip = 0; ucur_ph = 0; sef_ucur = 0;
        pole_dead = 0; all_dead = 0; trip_rst_mode = 0; volt_rst_mode = 0;
        stg1_dly = 0; stg2_dly = 0; stg2_en = 0;
        cyc(); cyc();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R13 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R13: reset state with a trip held during reset
        do_reset();
        rst_n = 1'b0; ext_trip_ph = 3'b001; cyc();
        check(bf1_trip, 1'b0, "R13 bf1 in reset");
        check(bf2_trip, 1'b0, "R13 bf2 in reset");
        check(bf_alarm, 1'b0, "R13 alarm in reset");

        // Table walk: R7 R8 R9 R10 R11
        for (int v = 0; v < 8; v++) begin
            int ph, d1, d2, n, rem;
            logic en, e1, e2;
            ph = int'(VEC[v][26:25]); d1 = int'(VEC[v][24:17]);
            d2 = int'(VEC[v][16:9]);  en = VEC[v][8];
            n  = int'(VEC[v][7:0]);
            rem = (d2 > d1) ? d2 - d1 : 0;
            e1 = (n >= d1);
            e2 = en && e1 && ((n - d1) >= rem);
            do_reset();
            trip_rst_mode = 2'd1;
            stg1_dly = 16'(d1); stg2_dly = 16'(d2); stg2_en = en;
            ext_trip_ph[ph] = 1'b1;
            cyc();
            ticks(n);
            check(bf1_trip, e1, "R7 table stage1");
            check(bf2_trip, e2, "R8 R9 R10 table stage2");
            check(bf_alarm, e1 | e2, "R11 table alarm");
        end

        // R2: code 0 clears on undercurrent with trip held
        do_reset();
        ext_trip_ph = 3'b001; cyc();
        check(bf1_trip, 1'b1, "R7 zero delay");
        ucur_ph = 3'b001; cyc();
        check(bf1_trip, 1'b0, "R2 undercurrent clears");

        // R3: code 1 per phase needs pole dead too
        do_reset();
        trip_rst_mode = 2'd1;
        ext_trip_ph = 3'b010; cyc();
        ucur_ph = 3'b010; cyc();
        check(bf1_trip, 1'b1, "R3 holds without pole dead");
        pole_dead = 3'b010; cyc();
        check(bf1_trip, 1'b0, "R3 clears on pole dead and uc");

        // R3: three-phase latch uses all-poles-dead
        do_reset();
        trip_rst_mode = 2'd1;
        ext_trip_3p = 1'b1; cyc();
        ucur_ph = 3'b111; pole_dead = 3'b111; cyc();
        check(bf1_trip, 1'b1, "R3 3ph holds without all dead");
        all_dead = 1'b1; cyc();
        check(bf1_trip, 1'b0, "R3 3ph clears on all dead");

        // R4: code 2 needs the trip to drop
        do_reset();
        trip_rst_mode = 2'd2;
        ext_trip_ph = 3'b100; cyc();
        ucur_ph = 3'b100; cyc();
        check(bf1_trip, 1'b1, "R4 holds while trip high");
        ext_trip_ph = 3'b000; cyc();
        check(bf1_trip, 1'b0, "R4 clears after trip drops");

        // R5: voltage latch follows its own code
        do_reset();
        trip_rst_mode = 2'd0; volt_rst_mode = 2'd2;
        volt_trip = 1'b1; cyc();
        ucur_ph = 3'b111; cyc();
        check(bf1_trip, 1'b1, "R5 voltage latch holds under code 2");
        volt_trip = 1'b0; cyc();
        check(bf1_trip, 1'b0, "R5 voltage latch clears");

        // R6: earth-fault latch clears on its own flag
        do_reset();
        trip_rst_mode = 2'd2; volt_rst_mode = 2'd2;
        sef_trip = 1'b1; cyc();
        check(bf1_trip, 1'b1, "R6 earth fault sets");
        ucur_ph = 3'b111; cyc();
        check(bf1_trip, 1'b1, "R6 ignores phase undercurrent");
        sef_ucur = 1'b1; cyc();
        check(bf1_trip, 1'b0, "R6 clears on own flag");

        // R1: each source alone initiates
        do_reset();
        for (int k = 0; k < 4; k++) begin
            case (k)
                0: int_trip_ph = 3'b001;
                1: wi1_trip_ph = 3'b010;
                2: wi2_trip_ph = 3'b100;
                default: wi2_trip_3p = 1'b1;
            endcase
            cyc();
            check(bf1_trip, 1'b1, "R1 source initiates");
            int_trip_ph = 0; wi1_trip_ph = 0; wi2_trip_ph = 0; wi2_trip_3p = 0;
            ucur_ph = 3'b111; cyc();
            check(bf1_trip, 1'b0, "R1 source cleared");
            ucur_ph = 3'b000; cyc();
        end

        // R12: clearing drops both stages and restarts counting
        do_reset();
        stg1_dly = 16'd2; stg2_dly = 16'd4; stg2_en = 1'b1;
        ext_trip_ph = 3'b001; cyc();
        ticks(2);
        check(bf1_trip, 1'b1, "R7 stage1 after two ticks");
        check(bf2_trip, 1'b0, "R8 stage2 not yet");
        ucur_ph = 3'b001; cyc();
        check(bf1_trip, 1'b0, "R12 stage1 drops");
        check(bf_alarm, 1'b0, "R12 alarm drops");
        ext_trip_ph = 3'b000; ucur_ph = 3'b000; cyc();
        ext_trip_ph = 3'b001; cyc();
        ticks(1);
        check(bf1_trip, 1'b0, "R12 count restarted");
        ticks(1);
        check(bf1_trip, 1'b1, "R12 stage1 after fresh count");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule